// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This block keeps the trap state of a small 32-bit RISC core. It holds four registers: the faulting data address, the status word, the cause word and the exception return address. From these it decides, in the same cycle, whether the pipeline must leave its current instruction stream. Synchronous faults arrive as a one-cycle pulse with a type code. External interrupts arrive on five level-sensitive request lines. A synchronous fault always wins over a pending interrupt.

The status word carries a five-bit interrupt mask and a six-bit stack of mode and enable pairs. Taking a trap pushes the stack by two bits and drops the core into kernel mode with interrupts off. A return strobe pops the stack again. Software reaches the registers through a numbered read/write port, which serves the coprocessor move instructions.

Top module: `exc_ctl`

## Requirements
- R1: After reset the status word, the stored cause code, the return address and the fault address are all zero, so `user_mode` and `int_en` are 0.
- R2: Register numbers are fixed: 8 is the fault address, 12 is status, 13 is cause and 14 is the return address. Any other number reads as 0. Status reads back only its implemented bits: mask in bits 12:8 and stack in bits 5:0.
- R3: The stack holds three pairs: current in bits 1:0, previous in 3:2 and old in 5:4. In each pair the upper bit is the mode (1 = user) and the lower bit is the interrupt enable. On every taken trap the six bits shift left by two and the current pair becomes 00. `user_mode` and `int_en` show the current pair.
- R4: A return strobe without a trap in the same cycle shifts bits 5:2 down into bits 3:0. Bits 5:4 and the mask are unchanged.
- R5: An interrupt is taken (`take_exc` high in the same cycle) only when the current enable bit is 1 and, for some level n, `irq_in[n]` and mask bit 8+n are both 1.
- R6: `exc_valid` forces `take_exc` high in that cycle whatever the enable and mask are. When an interrupt is also eligible, the fault's own code is the one recorded.
- R7: Cause reads the trap code in bits 5:2 and the live `irq_in` levels in bits 12:8. A taken interrupt records code 0. A synchronous fault uses one of the codes 4, 5, 6, 7, 8, 9, 10 or 12.
- R8: Every taken trap loads the return address register with `exc_pc`.
- R9: The fault address register loads `exc_addr` only on a fault with code 4 or 5, and holds its value on every other trap.
- R10: Software writes reach only status (register 12) and the return address (register 14). Writes to cause and to the fault address have no effect.
- R11: A trap in the same cycle as a software write or a return strobe takes precedence. The stack is pushed and the written stack value is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 5 | Level interrupt requests, one per level |
| exc_valid | input | 1 | Synchronous fault pulse |
| exc_code | input | 4 | Code of the synchronous fault |
| exc_pc | input | 32 | Address of the instruction being trapped |
| exc_addr | input | 32 | Data address of an address fault |
| reg_we | input | 1 | Software register write strobe |
| reg_sel | input | 5 | Register number for read and write |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Combinational read data for `reg_sel` |
| rfe | input | 1 | Return-from-trap strobe |
| take_exc | output | 1 | Trap request to the pipeline, same cycle |
| user_mode | output | 1 | Current mode bit (1 = user) |
| int_en | output | 1 | Current interrupt enable bit |

## Verification
The assertions assume that `exc_valid` comes with one of the eight legal fault codes. They also assume that the request lines stay high until software clears the source. One assertion checks the code assumption directly. The stimulus draws fault codes only from the legal set, and it lowers an interrupt line only after the handler cycle the vector describes. The bench drives every input half a cycle before the edge, so the assertions never see a fault code change during a cycle.

// File: rtl/exc_ctl.sv
module exc_ctl #(
  parameter int XLEN   = 32,
  parameter int NLVL   = 5,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLVL-1:0]   irq_in,
  input  logic              exc_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic [XLEN-1:0]   exc_addr,
  input  logic              reg_we,
  input  logic [4:0]        reg_sel,
  input  logic [XLEN-1:0]   reg_wdata,
  output logic [XLEN-1:0]   reg_rdata,
  input  logic              rfe,
  output logic              take_exc,
  output logic              user_mode,
  output logic              int_en
);

  localparam int STK_W    = 6;
  localparam int MASK_LSB = 8;
  localparam int CODE_LSB = 2;
  localparam logic [4:0] SEL_BADV = 5'd8;
  localparam logic [4:0] SEL_STAT = 5'd12;
  localparam logic [4:0] SEL_CAUS = 5'd13;
  localparam logic [4:0] SEL_EPC  = 5'd14;
  localparam logic [CODE_W-1:0] CODE_ADEL = CODE_W'(4);
  localparam logic [CODE_W-1:0] CODE_ADES = CODE_W'(5);

  logic [STK_W-1:0]  stk;
  logic [NLVL-1:0]   mask;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   epc_q;
  logic [XLEN-1:0]   badv_q;

  logic irq_hit, addr_err, wr_stat;

  assign irq_hit   = stk[0] & (|(irq_in & mask));
  assign take_exc  = exc_valid | irq_hit;
  assign addr_err  = exc_valid & ((exc_code == CODE_ADEL) | (exc_code == CODE_ADES));
  assign wr_stat   = reg_we & (reg_sel == SEL_STAT);
  assign user_mode = stk[1];
  assign int_en    = stk[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stk    <= '0;
      mask   <= '0;
      code_q <= '0;
      epc_q  <= '0;
      badv_q <= '0;
    end else if (take_exc) begin
      stk    <= {stk[STK_W-3:0], 2'b00};
      code_q <= exc_valid ? exc_code : '0;
      epc_q  <= exc_pc;
      if (addr_err) badv_q <= exc_addr;
    end else begin
      if (rfe)
        stk <= {stk[STK_W-1:STK_W-2], stk[STK_W-1:2]};
      else if (wr_stat)
        stk <= reg_wdata[STK_W-1:0];
      if (wr_stat)
        mask <= reg_wdata[MASK_LSB +: NLVL];
      if (reg_we && reg_sel == SEL_EPC)
        epc_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_BADV: reg_rdata = badv_q;
      SEL_STAT: begin
        reg_rdata[STK_W-1:0]         = stk;
        reg_rdata[MASK_LSB +: NLVL]  = mask;
      end
      SEL_CAUS: begin
        reg_rdata[CODE_LSB +: CODE_W] = code_q;
        reg_rdata[MASK_LSB +: NLVL]   = irq_in;
      end
      SEL_EPC:  reg_rdata = epc_q;
      default:  reg_rdata = '0;
    endcase
  end

  p_push_kernel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (!user_mode && !int_en));

  p_pop_keeps_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !take_exc) |=> $stable(stk[STK_W-1:STK_W-2]));

  p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && !exc_valid) |-> int_en);

  p_fault_code_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (code_q == $past(exc_code)));

  p_legal_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_code inside {4, 5, 6, 7, 8, 9, 10, 12}));

  p_epc_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (epc_q == $past(exc_pc)));

  p_badv_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_err |=> $stable(badv_q));

endmodule

// File: tb/sim_exc_ctl.sv
`timescale 1ns/100ps
module sim_exc_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  irq_in = '0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic [31:0] exc_addr = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rfe = 1'b0;
  logic        take_exc, user_mode, int_en;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_ctl u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .exc_valid(exc_valid),
    .exc_code(exc_code), .exc_pc(exc_pc), .exc_addr(exc_addr),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rfe(rfe), .take_exc(take_exc),
    .user_mode(user_mode), .int_en(int_en)
  );

  // {irq[21:17], ev[16], code[15:12], rfe[11], take[10], stack[9:4], code_exp[3:0]}
  localparam logic [21:0] VEC [12] = '{
    {5'h00, 1'b0, 4'd0,  1'b0, 1'b0, 6'h03, 4'd0},
    {5'h04, 1'b0, 4'd0,  1'b0, 1'b1, 6'h0C, 4'd0},
    {5'h04, 1'b0, 4'd0,  1'b0, 1'b0, 6'h0C, 4'd0},
    {5'h00, 1'b0, 4'd0,  1'b1, 1'b0, 6'h03, 4'd0},
    {5'h00, 1'b1, 4'd8,  1'b0, 1'b1, 6'h0C, 4'd8},
    {5'h00, 1'b1, 4'd12, 1'b0, 1'b1, 6'h30, 4'd12},
    {5'h00, 1'b0, 4'd0,  1'b1, 1'b0, 6'h3C, 4'd12},
    {5'h00, 1'b0, 4'd0,  1'b1, 1'b0, 6'h3F, 4'd12},
    {5'h10, 1'b1, 4'd10, 1'b0, 1'b1, 6'h3C, 4'd10},
    {5'h10, 1'b0, 4'd0,  1'b1, 1'b0, 6'h3F, 4'd10},
    {5'h10, 1'b0, 4'd0,  1'b0, 1'b1, 6'h3C, 4'd0},
    {5'h00, 1'b0, 4'd0,  1'b1, 1'b0, 6'h3F, 4'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] sel, output logic [31:0] val);
    reg_sel = sel;
    #0.2;
    val = reg_rdata;
  endtask

  task automatic edge_op(input logic ev, input logic [3:0] code, input logic [31:0] pc,
                         input logic [31:0] addr, input logic rf, input logic we,
                         input logic [4:0] sel, input logic [31:0] wd);
    @(negedge clk);
    exc_valid = ev; exc_code = code; exc_pc = pc; exc_addr = addr;
    rfe = rf; reg_we = we; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    #0.5;
    exc_valid = 1'b0; rfe = 1'b0; reg_we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] wd);
    edge_op(1'b0, 4'd0, 32'h0, 32'h0, 1'b0, 1'b1, sel, wd);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp_epc;
    irq_in = 5'h1F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    // R1 reset state; R5 requests ignored while enable is 0
    chk("R1 user_mode", {31'h0, user_mode}, 32'h0);
    chk("R1 int_en", {31'h0, int_en}, 32'h0);
    chk("R5 no take while disabled", {31'h0, take_exc}, 32'h0);
    rd(5'd12, v); chk("R1 status", v, 32'h0);
    rd(5'd13, v); chk("R7 cause pending live", v, 32'h0000_1F00);
    rd(5'd14, v); chk("R1 epc", v, 32'h0);
    rd(5'd8, v);  chk("R1 badvaddr", v, 32'h0);
    irq_in = 5'h00;

    // R2 register map and implemented status bits
    wr(5'd12, 32'hFFFF_FFFF);
    rd(5'd12, v); chk("R2 status readback", v, 32'h0000_1F3F);
    rd(5'd9, v);  chk("R2 unmapped 9", v, 32'h0);
    rd(5'd0, v);  chk("R2 unmapped 0", v, 32'h0);

    // R5 mask gating
    wr(5'd12, 32'h0000_0003);
    irq_in = 5'h1F; #0.2;
    chk("R5 all masked", {31'h0, take_exc}, 32'h0);
    irq_in = 5'h00;
    wr(5'd12, 32'h0000_0203);
    irq_in = 5'h01; #0.2;
    chk("R5 masked level 0", {31'h0, take_exc}, 32'h0);
    irq_in = 5'h02; #0.2;
    chk("R5 enabled level 1", {31'h0, take_exc}, 32'h1);
    irq_in = 5'h15; #0.2;
    chk("R5 other levels masked", {31'h0, take_exc}, 32'h0);
    rd(5'd13, v); chk("R7 pending mirrors lines", v, 32'h0000_1500);
    irq_in = 5'h00;

    // vector table: R3 R4 R5 R6 R7 R8
    wr(5'd12, 32'h0000_1F03);
    exp_epc = 32'h0;
    for (int i = 0; i < 12; i++) begin
      logic [21:0] t;
      logic [31:0] pc;
      t = VEC[i];
      pc = 32'h0040_0000 + 32'(i) * 4;
      @(negedge clk);
      irq_in = t[21:17]; exc_valid = t[16]; exc_code = t[15:12]; rfe = t[11];
      exc_pc = pc; exc_addr = 32'hA000_0000 + 32'(i);
      #0.5;
      chk($sformatf("R5 R6 take vec%0d", i), {31'h0, take_exc}, {31'h0, t[10]});
      @(posedge clk);
      #0.5;
      if (t[10]) exp_epc = pc;
      rd(5'd12, v); chk($sformatf("R3 R4 stack vec%0d", i), v, 32'h1F00 | 32'(t[9:4]));
      chk($sformatf("R3 mode pins vec%0d", i), {30'h0, user_mode, int_en}, 32'(t[5:4]));
      rd(5'd13, v); chk($sformatf("R6 R7 cause vec%0d", i), v, (32'(t[21:17]) << 8) | (32'(t[3:0]) << 2));
      rd(5'd14, v); chk($sformatf("R8 epc vec%0d", i), v, exp_epc);
      exc_valid = 1'b0; rfe = 1'b0;
    end
    @(negedge clk);
    irq_in = 5'h00;

    // R9 fault address capture
    edge_op(1'b1, 4'd5, 32'h0040_0100, 32'hDEAD_0000, 1'b0, 1'b0, 5'd0, 32'h0);
    rd(5'd8, v); chk("R9 store address fault", v, 32'hDEAD_0000);
    edge_op(1'b1, 4'd8, 32'h0040_0104, 32'h1111_1110, 1'b0, 1'b0, 5'd0, 32'h0);
    rd(5'd8, v); chk("R9 held on syscall", v, 32'hDEAD_0000);
    edge_op(1'b1, 4'd4, 32'h0040_0108, 32'h0BAD_0004, 1'b0, 1'b0, 5'd0, 32'h0);
    rd(5'd8, v); chk("R9 load address fault", v, 32'h0BAD_0004);

    // R10 software write reach
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, v); chk("R10 cause write ignored", v, 32'h0000_0010);
    wr(5'd8, 32'h0);
    rd(5'd8, v); chk("R10 badvaddr write ignored", v, 32'h0BAD_0004);
    wr(5'd14, 32'h0040_1234);
    rd(5'd14, v); chk("R10 epc writable", v, 32'h0040_1234);

    // R11 trap beats write and return
    wr(5'd12, 32'h0000_1F03);
    edge_op(1'b1, 4'd9, 32'h0040_0200, 32'h0, 1'b0, 1'b1, 5'd12, 32'h0000_0000);
    rd(5'd12, v); chk("R11 trap over status write", v, 32'h0000_1F0C);
    edge_op(1'b1, 4'd10, 32'h0040_0204, 32'h0, 1'b1, 1'b0, 5'd0, 32'h0);
    rd(5'd12, v); chk("R11 trap over return", v, 32'h0000_1F30);
    rd(5'd13, v); chk("R11 code recorded", v, 32'h0000_0028);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule